// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block settles the electrical level of every pin in a general purpose I/O bank. For each pin it derives what the controller itself drives: the output-data bit inverted by the polarity bit, gated by the output enable, with high levels suppressed on open-drain pins. It then merges this with an external driver and the pull resistors. Pins that are driven to opposite levels from both sides are flagged as contentions. Pins that nobody drives and that have no pull are flagged as undefined.

The resolved level, the undefined mask and the contention mask are combinational. The input-data word is masked by the input-enable register, corrected for polarity and registered every clock. Alongside it, a registered change vector gives the bits that toggled at that edge, for use by a downstream edge detector. The first update after reset reports no change. Without this, pins held high by their reset pull-ups would show up as false rising edges.

There is no streaming interface here. Every port is a plain level that holds until it is changed.

Top module: `gpio_pin_resolver`

## Requirements
- R1: The internal drive level of a pin is its output-data bit XOR its polarity bit. With output enabled, open-drain off and no external driver, `pin_lvl` equals `cfg_dout ^ cfg_pol`.
- R2: Internal drive is enabled when `cfg_oe` is 1, except that it is off when `cfg_odrain` is 1 and the drive level is high. Such a pin then behaves as undriven.
- R3: `pin_conflict` bit n is 1 exactly when pin n is driven internally and externally (`ext_drv`=1) and the two levels differ.
- R4: `pin_lvl` is the OR of two terms: `ext_lvl` where `ext_drv` is 1, and the internal level where internal drive is enabled.
- R5: A pin driven by neither side reads 1 when `cfg_pull_up` is 1 and 0 otherwise. A pull-up wins over a pull-down.
- R6: `pin_undef` bit n is 1 when pin n is in contention, or when it is driven by neither side and has neither pull enabled.
- R7: `din` takes the value `(pin_lvl & cfg_in_en) ^ cfg_pol` at each rising clock edge and holds it until the next edge.
- R8: At each edge after the first one following reset, `din_chg` takes the XOR of the old and new `din` values.
- R9: At the first clock edge after reset is released, `din_chg` is loaded with all zeros, whatever value `din` takes.
- R10: While `rst_n` is low, `din` and `din_chg` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dout | input | NPINS | Output data per pin |
| cfg_pol | input | NPINS | Polarity invert per pin |
| cfg_oe | input | NPINS | Output enable per pin |
| cfg_odrain | input | NPINS | Open-drain select per pin |
| cfg_pull_up | input | NPINS | Pull-up enable per pin |
| cfg_pull_dn | input | NPINS | Pull-down enable per pin |
| cfg_in_en | input | NPINS | Input enable mask |
| ext_drv | input | NPINS | 1 where an external driver is present |
| ext_lvl | input | NPINS | Level of the external driver |
| pin_lvl | output | NPINS | Resolved pin level |
| pin_undef | output | NPINS | Undefined pins |
| pin_conflict | output | NPINS | Pins in drive contention |
| din | output | NPINS | Registered input-data word |
| din_chg | output | NPINS | Bits of din toggled at the last edge |

## Verification
Contention detection and undefined marking can hit the same pin in the same cycle, because a contended pin must also be reported as undefined. The bench provokes this by driving random external levels against random enabled outputs. It judges both masks against an independent per-pin model on every clock. The reset release and the change vector also meet at one edge: pull-ups set at reset raise `din` at the first edge while `din_chg` must still read zero.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  // internal drive of one pin
  typedef struct packed {
    logic lvl;
    logic en;
  } pin_drive_t;
endpackage

// File: rtl/gpio_drive_bit.sv
module gpio_drive_bit
  import gpio_res_pkg::*;
(
  input  logic       dout,
  input  logic       pol,
  input  logic       oe,
  input  logic       odrain,
  output pin_drive_t drv
);
  always_comb begin
    drv.lvl = dout ^ pol;
    drv.en  = oe & ~(odrain & drv.lvl);
  end
endmodule

// File: rtl/gpio_pin_merge.sv
module gpio_pin_merge #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] int_lvl,
  input  logic [NPINS-1:0] int_en,
  input  logic [NPINS-1:0] ext_drv,
  input  logic [NPINS-1:0] ext_lvl,
  input  logic [NPINS-1:0] pull_up,
  input  logic [NPINS-1:0] pull_dn,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] undef,
  output logic [NPINS-1:0] conflict
);
  logic [NPINS-1:0] floating;

  always_comb begin
    floating = ~(int_en | ext_drv);
    conflict = int_en & ext_drv & (int_lvl ^ ext_lvl);
    lvl      = (ext_lvl & ext_drv) | (int_lvl & int_en) | (floating & pull_up);
    undef    = conflict | (floating & ~(pull_up | pull_dn));
  end
endmodule

// File: rtl/gpio_din_capture.sv
module gpio_din_capture #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] in_en,
  input  logic [NPINS-1:0] pol,
  output logic [NPINS-1:0] din,
  output logic [NPINS-1:0] chg
);
  logic [NPINS-1:0] din_nxt;
  logic             primed;

  assign din_nxt = (lvl & in_en) ^ pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din    <= '0;
      chg    <= '0;
      primed <= 1'b0;
    end else begin
      din    <= din_nxt;
      chg    <= primed ? (din ^ din_nxt) : '0;
      primed <= 1'b1;
    end
  end

  // R8: change vector equals old^new of din once primed
  p_chg_xor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> (chg == ($past(din) ^ din)));

  // R9: first update after reset reports no change
  p_first_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed) |-> (chg == '0));

  // R7: din follows masked, polarity-corrected level
  p_din_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (din == $past((lvl & in_en) ^ pol)));
endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver
  import gpio_res_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cfg_dout,
  input  logic [NPINS-1:0] cfg_pol,
  input  logic [NPINS-1:0] cfg_oe,
  input  logic [NPINS-1:0] cfg_odrain,
  input  logic [NPINS-1:0] cfg_pull_up,
  input  logic [NPINS-1:0] cfg_pull_dn,
  input  logic [NPINS-1:0] cfg_in_en,
  input  logic [NPINS-1:0] ext_drv,
  input  logic [NPINS-1:0] ext_lvl,
  output logic [NPINS-1:0] pin_lvl,
  output logic [NPINS-1:0] pin_undef,
  output logic [NPINS-1:0] pin_conflict,
  output logic [NPINS-1:0] din,
  output logic [NPINS-1:0] din_chg
);
  pin_drive_t       drv [NPINS];
  logic [NPINS-1:0] int_lvl;
  logic [NPINS-1:0] int_en;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_drive_bit u_drv (
      .dout   (cfg_dout[i]),
      .pol    (cfg_pol[i]),
      .oe     (cfg_oe[i]),
      .odrain (cfg_odrain[i]),
      .drv    (drv[i])
    );
    assign int_lvl[i] = drv[i].lvl;
    assign int_en[i]  = drv[i].en;
  end

  gpio_pin_merge #(.NPINS(NPINS)) u_merge (
    .int_lvl  (int_lvl),
    .int_en   (int_en),
    .ext_drv  (ext_drv),
    .ext_lvl  (ext_lvl),
    .pull_up  (cfg_pull_up),
    .pull_dn  (cfg_pull_dn),
    .lvl      (pin_lvl),
    .undef    (pin_undef),
    .conflict (pin_conflict)
  );

  gpio_din_capture #(.NPINS(NPINS)) u_din (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_lvl),
    .in_en (cfg_in_en),
    .pol   (cfg_pol),
    .din   (din),
    .chg   (din_chg)
  );

  // R6: every contended pin is also undefined
  p_conflict_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_conflict & ~pin_undef) == '0);

  // R3: contention needs an external driver
  p_conflict_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_conflict & ~ext_drv) == '0);

  // R5: floating pin with pull-up reads high
  p_pullup_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (~ext_drv & ~cfg_oe & cfg_pull_up & ~pin_lvl) == '0);

  // R2: open-drain pin never drives high into a low external level
  p_odrain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_odrain & ext_drv & ~ext_lvl & pin_conflict) == '0);
endmodule

// File: tb/sim_gpio_pin_resolver.sv
module sim_gpio_pin_resolver;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dout = '0, pol = '0, oe = '0, od = '0, pu = '0, pd = '0, ie = '0, xd = '0, xl = '0;
  logic [N-1:0] pin_lvl, pin_undef, pin_conflict, din, din_chg;
  int checks = 0, failures = 0;
  logic [N-1:0] m_din = '0, m_chg = '0;
  bit m_primed = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_pin_resolver #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dout(dout), .cfg_pol(pol), .cfg_oe(oe),
    .cfg_odrain(od), .cfg_pull_up(pu), .cfg_pull_dn(pd), .cfg_in_en(ie),
    .ext_drv(xd), .ext_lvl(xl), .pin_lvl(pin_lvl), .pin_undef(pin_undef),
    .pin_conflict(pin_conflict), .din(din), .din_chg(din_chg));

  // behavioural per-pin model of the combinational outputs
  function automatic logic [3*N-1:0] model_comb();
    logic [N-1:0] l, u, c;
    for (int i = 0; i < N; i++) begin
      bit mine_lvl = (dout[i] != pol[i]);
      bit mine_on  = oe[i] && !(od[i] && mine_lvl);
      bit theirs   = xd[i];
      c[i] = mine_on && theirs && (mine_lvl != xl[i]);
      if (!mine_on && !theirs) begin
        l[i] = pu[i];
        u[i] = !pu[i] && !pd[i];
      end else begin
        l[i] = (theirs && xl[i]) || (mine_on && mine_lvl);
        u[i] = c[i];
      end
    end
    return {l, u, c};
  endfunction

  always @(posedge clk) begin
    logic [3*N-1:0] mc;
    logic [N-1:0] nxt;
    mc = model_comb();
    nxt = (mc[3*N-1:2*N] & ie) ^ pol;
    if (!rst_n) begin
      m_din <= '0; m_chg <= '0; m_primed <= 0;
    end else begin
      m_chg <= m_primed ? (m_din ^ nxt) : '0;
      m_din <= nxt;
      m_primed <= 1;
    end
  end

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [3*N-1:0] mc = model_comb();
    chk("R4/R5 level", pin_lvl, mc[3*N-1:2*N]);
    chk("R6 undef", pin_undef, mc[2*N-1:N]);
    chk("R3 conflict", pin_conflict, mc[N-1:0]);
    chk("R7 din", din, m_din);
    chk("R8 chg", din_chg, m_chg);
  endtask

  initial begin
    pu = 32'hFFFF_0000; pd = 32'h0000_FF00; ie = '1;
    repeat (3) @(negedge clk);
    chk("R10 din reset", din, '0);
    chk("R10 chg reset", din_chg, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 din after first edge", din, 32'hFFFF_0000);
    chk("R9 chg quiet", din_chg, '0);
    compare_all();
    // R1: plain push-pull drive with polarity
    oe = '1; pol = 32'hFFFF_0000; dout = 32'h00FF_00FF;
    @(negedge clk);
    chk("R1 drive level", pin_lvl, 32'hFF00_00FF);
    chk("R8 chg after drive", din_chg, 32'hFFFF_0000 ^ (32'hFF00_00FF ^ 32'hFFFF_0000));
    // R2: open-drain suppresses high drive; pull-down keeps those low
    od = '1; pu = '0; pd = '1;
    @(negedge clk);
    chk("R2 open drain level", pin_lvl, '0);
    chk("R2 open drain undef", pin_undef, '0);
    // R2 with no pulls: high-level pins float to undefined
    pd = '0;
    @(negedge clk);
    chk("R2 floating undef", pin_undef, 32'hFF00_00FF);
    // R3/R6: push-pull against external opposite
    od = '0; xd = 32'h0000_FFFF; xl = '0;
    @(negedge clk);
    chk("R3 conflict directed", pin_conflict, 32'h0000_00FF);
    chk("R6 conflict is undef", pin_undef & 32'h0000_FFFF, 32'h0000_00FF);
    // random sweep, compared every clock
    for (int k = 0; k < 2000; k++) begin
      dout = $urandom(); pol = $urandom(); oe = $urandom(); od = $urandom();
      pu = $urandom(); pd = $urandom(); ie = $urandom();
      xd = $urandom(); xl = $urandom();
      @(negedge clk);
      compare_all();
    end
    // R9 again: reset mid-run with pull-ups, din high at first edge
    rst_n = 1'b0; oe = '0; xd = '0; pu = '1; pol = '0; ie = '1;
    @(negedge clk);
    chk("R10 din in reset", din, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 din high", din, '1);
    chk("R9 chg zero", din_chg, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule